// File: doc/BRIEF.md
# Windowed PCI Target Claim and Retry Controller

This block decides whether, and in which clock, a PCI target claims a bus cycle. It compares each new address phase against four programmable address windows. A window has a base, a power-of-two size mask, an enable bit and a flag that marks it as bound for a remote ISA bus. For an ordinary window the block drives DEVSEL# at medium decode timing and holds it until the bus goes idle. The data transfer itself belongs to other logic.

For a window marked as ISA, the block claims the cycle and ends it at once with a retry, so that the remote side can find out whether it owns that address. A slow-decode enable bit moves ISA-window claims from the medium slot to the slow slot. In the slow slot the block claims only if no other agent drove DEVSEL# in the fast or the medium slot. After each retry the block raises a forward request on a valid/ready interface. If the remote side then answers that the cycle is not its own, the block lets the next repeat of that exact cycle pass unclaimed, so that the host's subtractive decoder can take it.

Back-pressure rules for the forward request: `fwd_valid`, `fwd_addr` and `fwd_cmd` stay stable until a clock edge on which `fwd_ready` is high. After that handshake the block waits for one `dest_valid` pulse. While a request is outstanding or a response is still awaited, further retries issue no new request. `dest_valid` is ignored when no response is awaited.

Top module: `tgt_claim_ctrl`

## Requirements
- R1: A window hits when its enable bit is 1 and `(ad & mask) == (base & mask)`, where a mask bit of 1 means the address bit is compared. A cycle that hits no enabled window is never claimed, so `devsel_n` and `stop_n` stay 1.
- R2: When several enabled windows hit, the one with the lowest index decides the claim type.
- R3: The clock after the address phase (fast slot) never shows `devsel_n` low. A hit on a non-ISA window drives `devsel_n` low in the second clock after the address phase, with `stop_n` high. `devsel_n` stays low until an edge samples `frame_n` and `irdy_n` both high, and it is 1 from the next clock.
- R4: With slow decode off, a hit on an ISA window drives `devsel_n` and `stop_n` low together in the second clock after the address phase. Both stay low until an edge samples `irdy_n` low, and then both return to 1 together in the next clock.
- R5: With `slow_dec_en` = 1, an ISA-window hit is claimed with a retry in the third clock after the address phase. This happens only if `bus_devsel_n` was sampled high in both the fast and the medium clock. Otherwise the block does not claim the cycle.
- R6: `slow_dec_en` has no effect on non-ISA windows, which keep medium timing.
- R7: In the clock after a retry completes, `fwd_valid` rises with `fwd_addr`/`fwd_cmd` equal to the retried cycle's address and command. These outputs hold until accepted by `fwd_ready`. No new request replaces one that is outstanding.
- R8: A `dest_valid` pulse with `dest_remote` = 0 causes the next address phase with the same address and command to go unclaimed. Exactly one such repeat is ignored.
- R9: The pending ignore is dropped when any other address phase arrives, or 32 clocks after it was set. A later repeat of the cycle is then claimed again.
- R10: A `dest_valid` pulse with `dest_remote` = 1 sets no ignore, so the repeated cycle is claimed and retried again.
- R11: After reset `devsel_n` = 1, `stop_n` = 1 and `fwd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | Bus FRAME#, active low |
| irdy_n | input | 1 | Bus IRDY#, active low |
| ad | input | 32 | Address/data bus |
| cbe | input | 4 | Command / byte enables |
| bus_devsel_n | input | 1 | DEVSEL# as driven by other agents |
| win_base | input | 128 | Four window bases, window i at [32i+31:32i] |
| win_mask | input | 128 | Four window compare masks, same packing |
| win_isa | input | 4 | Per-window ISA flag |
| win_en | input | 4 | Per-window enable |
| slow_dec_en | input | 1 | Move ISA-window claims to slow decode |
| devsel_n | output | 1 | Own DEVSEL#, active low |
| stop_n | output | 1 | Own STOP#, active low, for retry |
| fwd_valid | output | 1 | Forward request valid |
| fwd_ready | input | 1 | Forward request accepted |
| fwd_addr | output | 32 | Address of the retried cycle |
| fwd_cmd | output | 4 | Command of the retried cycle |
| dest_valid | input | 1 | Destination answer strobe |
| dest_remote | input | 1 | 1: cycle belongs to the remote bus |

## Verification
A wrong decode-slot counter shows up in the clock after the address phase or in the one after it. There DEVSEL# either appears in the fast slot or misses the medium or slow slot, so every directed cycle samples all three slots. A stuck retry state shows up as STOP# outlasting the first IRDY# data phase, or as DEVSEL# and STOP# releasing in different clocks. A corrupt ignore record appears only on the next repeat of the cycle. A correct repeat is claimed when it should pass, or passes when it should be claimed. The bench therefore repeats cycles after the ignore was set, after the timeout, and after an unrelated address phase.

// File: rtl/tgt_claim_pkg.sv
package tgt_claim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC1,
    ST_DEC2,
    ST_CLAIM,
    ST_RETRY,
    ST_WAIT
  } claim_st_e;
endpackage

// File: rtl/tgt_win_decode.sv
module tgt_win_decode #(
  parameter int NWIN = 4,
  parameter int AW   = 32
) (
  input  logic [AW-1:0]      addr,
  input  logic [NWIN*AW-1:0] base,
  input  logic [NWIN*AW-1:0] mask,
  input  logic [NWIN-1:0]    isa,
  input  logic [NWIN-1:0]    en,
  output logic               hit,
  output logic               hit_isa
);
  logic [NWIN-1:0] raw;
  logic [NWIN-1:0] sel;

  generate
    for (genvar i = 0; i < NWIN; i++) begin : g_win
      assign raw[i] = en[i] &&
        ((addr & mask[i*AW +: AW]) == (base[i*AW +: AW] & mask[i*AW +: AW]));
    end
  endgenerate

  // lowest-index hit wins
  assign sel     = raw & (~raw + 1'b1);
  assign hit     = |raw;
  assign hit_isa = |(sel & isa);

  always_comb begin
    if (!$isunknown(raw)) begin
      assert_pick_in_raw_R2: assert (((sel & ~raw) == '0) && (hit == (sel != '0)));
    end
  end
endmodule

// File: rtl/tgt_retry_ignore.sv
module tgt_retry_ignore #(
  parameter int AW  = 32,
  parameter int CW  = 4,
  parameter int TMO = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cur_addr,
  input  logic [CW-1:0] cur_cmd,
  input  logic          arm,
  input  logic [AW-1:0] arm_addr,
  input  logic [CW-1:0] arm_cmd,
  output logic          match
);
  localparam int TW = (TMO > 1) ? $clog2(TMO) : 1;

  logic          armed;
  logic [TW-1:0] cnt;
  logic [AW-1:0] rec_addr;
  logic [CW-1:0] rec_cmd;
  logic          expire;

  assign expire = (cnt == TW'(TMO - 1));
  assign match  = armed && (cur_addr == rec_addr) && (cur_cmd == rec_cmd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      rec_addr <= '0;
      rec_cmd  <= '0;
    end else if (arm) begin
      armed    <= 1'b1;
      cnt      <= '0;
      rec_addr <= arm_addr;
      rec_cmd  <= arm_cmd;
    end else if (armed) begin
      if (start || expire) armed <= 1'b0;
      else                 cnt   <= cnt + 1'b1;
    end
  end

  assert_expire_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && expire && !arm) |=> !match);
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !arm) |=> !match);
  assert_arm_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed);
endmodule

// File: rtl/tgt_claim_fsm.sv
module tgt_claim_fsm
  import tgt_claim_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          irdy_n,
  input  logic          bus_devsel_n,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] cmd,
  input  logic          hit,
  input  logic          hit_isa,
  input  logic          ign_match,
  input  logic          slow_en,
  input  logic          fwd_ready,
  input  logic          dest_valid,
  input  logic          dest_remote,
  output logic          start,
  output logic          devsel_n,
  output logic          stop_n,
  output logic          fwd_valid,
  output logic [AW-1:0] fwd_addr,
  output logic [CW-1:0] fwd_cmd,
  output logic          ign_arm
);
  claim_st_e     st;
  logic          frame_q;
  logic          isa_q;
  logic          slow_q;
  logic          fast_seen;
  logic          wait_resp;
  logic [AW-1:0] cyc_addr;
  logic [CW-1:0] cyc_cmd;
  logic          retry_done;

  assign start      = (st == ST_IDLE) && !frame_n && frame_q;
  assign retry_done = (st == ST_RETRY) && !irdy_n;
  assign ign_arm    = wait_resp && dest_valid && !dest_remote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      frame_q   <= 1'b1;
      devsel_n  <= 1'b1;
      stop_n    <= 1'b1;
      isa_q     <= 1'b0;
      slow_q    <= 1'b0;
      fast_seen <= 1'b0;
      cyc_addr  <= '0;
      cyc_cmd   <= '0;
    end else begin
      frame_q <= frame_n;
      case (st)
        ST_IDLE: begin
          if (start && hit && !ign_match) begin
            st       <= ST_DEC1;
            isa_q    <= hit_isa;
            slow_q   <= hit_isa && slow_en;
            cyc_addr <= addr;
            cyc_cmd  <= cmd;
          end else if (start) begin
            st <= ST_WAIT;
          end
        end
        ST_DEC1: begin
          if (slow_q) begin
            st        <= ST_DEC2;
            fast_seen <= !bus_devsel_n;
          end else begin
            devsel_n <= 1'b0;
            stop_n   <= !isa_q;
            st       <= isa_q ? ST_RETRY : ST_CLAIM;
          end
        end
        ST_DEC2: begin
          if (bus_devsel_n && !fast_seen) begin
            devsel_n <= 1'b0;
            stop_n   <= 1'b0;
            st       <= ST_RETRY;
          end else begin
            st <= ST_WAIT;
          end
        end
        ST_CLAIM: begin
          if (frame_n && irdy_n) begin
            devsel_n <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        ST_RETRY: begin
          if (!irdy_n) begin
            devsel_n <= 1'b1;
            stop_n   <= 1'b1;
            st       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (frame_n && irdy_n) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // forward request channel
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      wait_resp <= 1'b0;
      fwd_addr  <= '0;
      fwd_cmd   <= '0;
    end else if (retry_done && !fwd_valid && !wait_resp) begin
      fwd_valid <= 1'b1;
      fwd_addr  <= cyc_addr;
      fwd_cmd   <= cyc_cmd;
    end else if (fwd_valid && fwd_ready) begin
      fwd_valid <= 1'b0;
      wait_resp <= 1'b1;
    end else if (wait_resp && dest_valid) begin
      wait_resp <= 1'b0;
    end
  end

  assert_no_fast_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> devsel_n);
  assert_stop_needs_devsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_n |-> !devsel_n);
  assert_release_together_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_n) |-> $rose(devsel_n));
  assert_slow_yields_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DEC2 && !bus_devsel_n) |=> devsel_n);
  assert_fwd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_addr) && $stable(fwd_cmd)));
endmodule

// File: rtl/tgt_claim_ctrl.sv
module tgt_claim_ctrl #(
  parameter int NWIN = 4,
  parameter int AW   = 32,
  parameter int CW   = 4,
  parameter int TMO  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_n,
  input  logic               irdy_n,
  input  logic [AW-1:0]      ad,
  input  logic [CW-1:0]      cbe,
  input  logic               bus_devsel_n,
  input  logic [NWIN*AW-1:0] win_base,
  input  logic [NWIN*AW-1:0] win_mask,
  input  logic [NWIN-1:0]    win_isa,
  input  logic [NWIN-1:0]    win_en,
  input  logic               slow_dec_en,
  output logic               devsel_n,
  output logic               stop_n,
  output logic               fwd_valid,
  input  logic               fwd_ready,
  output logic [AW-1:0]      fwd_addr,
  output logic [CW-1:0]      fwd_cmd,
  input  logic               dest_valid,
  input  logic               dest_remote
);
  logic hit;
  logic hit_isa;
  logic start;
  logic ign_match;
  logic ign_arm;

  tgt_win_decode #(.NWIN(NWIN), .AW(AW)) u_dec (
    .addr    (ad),
    .base    (win_base),
    .mask    (win_mask),
    .isa     (win_isa),
    .en      (win_en),
    .hit     (hit),
    .hit_isa (hit_isa)
  );

  tgt_retry_ignore #(.AW(AW), .CW(CW), .TMO(TMO)) u_ign (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cur_addr (ad),
    .cur_cmd  (cbe),
    .arm      (ign_arm),
    .arm_addr (fwd_addr),
    .arm_cmd  (fwd_cmd),
    .match    (ign_match)
  );

  tgt_claim_fsm #(.AW(AW), .CW(CW)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .bus_devsel_n (bus_devsel_n),
    .addr         (ad),
    .cmd          (cbe),
    .hit          (hit),
    .hit_isa      (hit_isa),
    .ign_match    (ign_match),
    .slow_en      (slow_dec_en),
    .fwd_ready    (fwd_ready),
    .dest_valid   (dest_valid),
    .dest_remote  (dest_remote),
    .start        (start),
    .devsel_n     (devsel_n),
    .stop_n       (stop_n),
    .fwd_valid    (fwd_valid),
    .fwd_addr     (fwd_addr),
    .fwd_cmd      (fwd_cmd),
    .ign_arm      (ign_arm)
  );
endmodule

// File: tb/tgt_claim_ctrl_bench.sv
module tgt_claim_ctrl_bench;
  localparam int K_NONE = 0;
  localparam int K_MED  = 1;
  localparam int K_MRT  = 2;
  localparam int K_SRT  = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         frame_n = 1'b1;
  logic         irdy_n = 1'b1;
  logic [31:0]  ad = '0;
  logic [3:0]   cbe = '0;
  logic         bus_devsel_n = 1'b1;
  logic [127:0] win_base;
  logic [127:0] win_mask;
  logic [3:0]   win_isa;
  logic [3:0]   win_en;
  logic         slow_dec_en = 1'b0;
  logic         devsel_n;
  logic         stop_n;
  logic         fwd_valid;
  logic         fwd_ready = 1'b0;
  logic [31:0]  fwd_addr;
  logic [3:0]   fwd_cmd;
  logic         dest_valid = 1'b0;
  logic         dest_remote = 1'b0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  tgt_claim_ctrl u_tgt_claim_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad), .cbe(cbe),
    .bus_devsel_n(bus_devsel_n), .win_base(win_base), .win_mask(win_mask),
    .win_isa(win_isa), .win_en(win_en), .slow_dec_en(slow_dec_en),
    .devsel_n(devsel_n), .stop_n(stop_n), .fwd_valid(fwd_valid), .fwd_ready(fwd_ready),
    .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd), .dest_valid(dest_valid), .dest_remote(dest_remote)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_pins(input string req, input string what, input bit exp_dev, input bit exp_stop);
    chk(devsel_n === exp_dev && stop_n === exp_stop, req, what,
        {30'd0, devsel_n, stop_n}, {30'd0, exp_dev, exp_stop});
  endtask

  // one bus cycle; checks fast, medium and slow slots and the release
  task automatic bus_cycle(input logic [31:0] a, input logic [3:0] c, input bit oth_f,
                           input bit oth_m, input int kind, input string req);
    @(negedge clk);
    frame_n = 1'b0; ad = a; cbe = c; irdy_n = 1'b1; bus_devsel_n = 1'b1;
    @(negedge clk);
    chk_pins(req, "fast slot", 1'b1, 1'b1);
    irdy_n = 1'b0; ad = '0; bus_devsel_n = oth_f ? 1'b0 : 1'b1;
    @(negedge clk);
    chk_pins(req, "medium slot", (kind == K_MED || kind == K_MRT) ? 1'b0 : 1'b1,
             (kind == K_MRT) ? 1'b0 : 1'b1);
    bus_devsel_n = (oth_f || oth_m) ? 1'b0 : 1'b1;
    @(negedge clk);
    chk_pins(req, "slow slot", (kind == K_MED || kind == K_SRT) ? 1'b0 : 1'b1,
             (kind == K_SRT) ? 1'b0 : 1'b1);
    if (kind == K_SRT) begin
      @(negedge clk);
      chk_pins(req, "slow retry release", 1'b1, 1'b1);
    end
    frame_n = 1'b1; irdy_n = 1'b1; bus_devsel_n = 1'b1;
    @(negedge clk);
    chk_pins(req, "idle after cycle", 1'b1, 1'b1);
  endtask

  task automatic fwd_complete(input logic [31:0] a, input logic [3:0] c, input bit remote);
    chk(fwd_valid === 1'b1 && fwd_addr === a && fwd_cmd === c, "R7", "forward request",
        {fwd_valid, fwd_cmd, fwd_addr[26:0]}, {1'b1, c, a[26:0]});
    fwd_ready = 1'b1;
    @(negedge clk);
    fwd_ready = 1'b0; dest_valid = 1'b1; dest_remote = remote;
    @(negedge clk);
    dest_valid = 1'b0; dest_remote = 1'b0;
    chk(fwd_valid === 1'b0, "R7", "forward accepted", {31'd0, fwd_valid}, 32'd0);
  endtask

  task automatic t_reset;
    chk_pins("R11", "reset pins", 1'b1, 1'b1);
    chk(fwd_valid === 1'b0, "R11", "reset fwd_valid", {31'd0, fwd_valid}, 32'd0);
  endtask

  task automatic t_decode;
    bus_cycle(32'h0000_1010, 4'h6, 1'b0, 1'b0, K_MED, "R3");
    bus_cycle(32'h0000_1084, 4'h6, 1'b0, 1'b0, K_MED, "R2");
    bus_cycle(32'h0000_0314, 4'h2, 1'b0, 1'b0, K_NONE, "R1");
    bus_cycle(32'h0000_2010, 4'h2, 1'b0, 1'b0, K_NONE, "R1");
    chk(fwd_valid === 1'b0, "R1", "no forward on plain claims", {31'd0, fwd_valid}, 32'd0);
  endtask

  task automatic t_retry;
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_MRT, "R4");
    fwd_complete(32'h0000_0304, 4'h2, 1'b1);
  endtask

  task automatic t_slow;
    slow_dec_en = 1'b1;
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_SRT, "R5");
    fwd_complete(32'h0000_0304, 4'h2, 1'b1);
    bus_cycle(32'h0000_0304, 4'h2, 1'b1, 1'b0, K_NONE, "R5");
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b1, K_NONE, "R5");
    bus_cycle(32'h0000_1010, 4'h6, 1'b0, 1'b0, K_MED, "R6");
    slow_dec_en = 1'b0;
  endtask

  task automatic t_backpressure;
    bus_cycle(32'h0000_0308, 4'h3, 1'b0, 1'b0, K_MRT, "R7");
    repeat (5) @(negedge clk);
    chk(fwd_valid === 1'b1 && fwd_addr === 32'h0000_0308, "R7", "held under back-pressure",
        fwd_addr, 32'h0000_0308);
    bus_cycle(32'h0000_030C, 4'h2, 1'b0, 1'b0, K_MRT, "R7");
    fwd_complete(32'h0000_0308, 4'h3, 1'b1);
    repeat (3) @(negedge clk);
    chk(fwd_valid === 1'b0, "R7", "no second request", {31'd0, fwd_valid}, 32'd0);
  endtask

  task automatic t_ignore;
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_MRT, "R8");
    fwd_complete(32'h0000_0304, 4'h2, 1'b0);
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_NONE, "R8");
    chk(fwd_valid === 1'b0, "R8", "ignored cycle not forwarded", {31'd0, fwd_valid}, 32'd0);
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_MRT, "R8");
    fwd_complete(32'h0000_0304, 4'h2, 1'b1);
  endtask

  task automatic t_clear;
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_MRT, "R9");
    fwd_complete(32'h0000_0304, 4'h2, 1'b0);
    repeat (40) @(negedge clk);
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_MRT, "R9");
    fwd_complete(32'h0000_0304, 4'h2, 1'b0);
    bus_cycle(32'h0000_0308, 4'h2, 1'b0, 1'b0, K_MRT, "R9");
    fwd_complete(32'h0000_0308, 4'h2, 1'b1);
    bus_cycle(32'h0000_0304, 4'h2, 1'b0, 1'b0, K_MRT, "R9");
    fwd_complete(32'h0000_0304, 4'h2, 1'b1);
  endtask

  task automatic t_remote;
    bus_cycle(32'h0000_0300, 4'h3, 1'b0, 1'b0, K_MRT, "R10");
    fwd_complete(32'h0000_0300, 4'h3, 1'b1);
    bus_cycle(32'h0000_0300, 4'h3, 1'b0, 1'b0, K_MRT, "R10");
    fwd_complete(32'h0000_0300, 4'h3, 1'b1);
  endtask

  initial begin
    win_base = {32'h0000_2000, 32'h0000_1080, 32'h0000_0300, 32'h0000_1000};
    win_mask = {32'hFFFF_F000, 32'hFFFF_FFC0, 32'hFFFF_FFF0, 32'hFFFF_FF00};
    win_isa  = 4'b1110;
    win_en   = 4'b0111;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_decode();
    t_retry();
    t_slow();
    t_backpressure();
    t_ignore();
    t_clear();
    t_remote();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule